// File: doc/BRIEF.md
# Two-Pointer Sharer Directory Entry

This block keeps the coherence record for a single memory block shared by up to eight caches. The record holds two pointer slots, each with a valid bit and a cache number, and one bit that says whether a cache owns the block for writing. A single request port carries read and write-permission requests. When the record must change before a request can be honoured, the block sends invalidation commands as a cache bit mask. It then collects acknowledgements and afterwards issues a one-cycle grant.

There are only two slots, so a third reader cannot simply be added. The block picks one current sharer with a one-bit round-robin pointer and invalidates it. The newcomer takes that slot. Writes and reads of a dirty block shrink the record to a single pointer. The surrounding fabric can see the record through the entry state outputs.

Top module: `lp_dir_entry`

## Requirements
- R1: After reset no slot is valid, the entry is clean, `req_ready` is high, and the round-robin pointer selects slot 0.
- R2: A read from a cache that is not recorded, while the entry is clean and a slot is free, is granted in the cycle after acceptance with no invalidation. The reader goes into the lowest-numbered free slot (slot 0 before slot 1) and the entry stays clean.
- R3: A read from a cache that is already recorded is granted in the cycle after acceptance with no invalidation, and slots, validity and the dirty bit are left unchanged.
- R4: A read from an unrecorded cache while both slots are valid and the entry is clean invalidates the cache in the slot picked by the round-robin pointer. `inv_mask` bit n stands for cache n. After acknowledgement the reader replaces that slot and the pointer toggles, so successive evictions alternate between slot 0 and slot 1.
- R5: A write request invalidates every recorded cache other than the writer, and never the writer itself. When done, the entry is dirty, slot 0 holds the writer, and slot 1 is invalid. `grant_write` is high with the grant.
- R6: A read from another cache while the entry is dirty invalidates the owner. After acknowledgement the entry is clean, slot 0 holds the reader, and slot 1 is invalid.
- R7: After an invalidation, no grant is issued while any invalidated cache has not acknowledged. `req_ready` stays low from acceptance until the grant cycle ends. The grant arrives in the cycle after the edge that samples the last outstanding acknowledgement.
- R8: At most two caches are recorded, two valid slots never name the same cache, and a dirty entry has exactly one valid slot (slot 0).
- R9: Acknowledgement bits for caches that have no invalidation outstanding are ignored and do not bring the grant forward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write permission, 0 = read copy |
| req_id | input | 3 | Requesting cache number |
| req_ready | output | 1 | Entry idle and able to accept a request |
| inv_valid | output | 1 | One-cycle invalidation command |
| inv_mask | output | 8 | Caches to invalidate, bit n = cache n |
| ack_mask | input | 8 | Invalidation acknowledgements, bit n = cache n |
| grant_valid | output | 1 | One-cycle grant pulse |
| grant_write | output | 1 | Grant is for write permission |
| grant_id | output | 3 | Cache receiving the grant |
| dir_dirty | output | 1 | Entry owned for writing |
| ptr_vld | output | 2 | Valid bit per slot, bit 0 = slot 0 |
| ptr_id | output | 6 | Slot cache numbers, [2:0] = slot 0, [5:3] = slot 1 |

## Verification
The request sequence fills the slots from empty, repeats a read by a recorded cache, and then pushes two more readers. Those two prove that the evicted slot alternates instead of always hitting the oldest or the same slot. Writes are tried against two foreign sharers with split and stray acknowledgements, and against an entry already owned by the writer. The split case tells a grant that waits for every acknowledgement apart from one that fires on the first. The owner case tells a correct self-exclusion apart from an invalidation of the writer. A final read of the dirty block checks the owner handover to a clean single sharer.

// File: rtl/lp_dir_entry.sv
module lp_dir_entry #(
  parameter int NCACHE = 8,
  localparam int IDW = $clog2(NCACHE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [IDW-1:0]    req_id,
  output logic              req_ready,
  output logic              inv_valid,
  output logic [NCACHE-1:0] inv_mask,
  input  logic [NCACHE-1:0] ack_mask,
  output logic              grant_valid,
  output logic              grant_write,
  output logic [IDW-1:0]    grant_id,
  output logic              dir_dirty,
  output logic [1:0]        ptr_vld,
  output logic [2*IDW-1:0]  ptr_id
);

  typedef enum logic [1:0] {S_IDLE, S_INV, S_WAIT, S_DONE} st_t;

  st_t               st;
  logic              op_wr_q;
  logic [IDW-1:0]    op_id_q;
  logic [NCACHE-1:0] pend_q;
  logic              dirty_q;
  logic [1:0]        vld_q;
  logic [IDW-1:0]    id0_q, id1_q;
  logic              repl_q;

  function automatic logic [NCACHE-1:0] oh(input logic [IDW-1:0] i);
    oh = '0;
    oh[i] = 1'b1;
  endfunction

  logic              accept, cur_wr, hit0, hit1, hit, go_done;
  logic [IDW-1:0]    cur_id;
  logic [NCACHE-1:0] others, evict, need, pend_left;

  assign req_ready = (st == S_IDLE);
  assign accept    = req_valid && req_ready;
  assign cur_wr    = (st == S_IDLE) ? req_write : op_wr_q;
  assign cur_id    = (st == S_IDLE) ? req_id : op_id_q;

  assign hit0 = vld_q[0] && (id0_q == cur_id);
  assign hit1 = vld_q[1] && (id1_q == cur_id);
  assign hit  = hit0 || hit1;

  assign others = ((vld_q[0] && !hit0) ? oh(id0_q) : '0) |
                  ((vld_q[1] && !hit1) ? oh(id1_q) : '0);
  assign evict  = repl_q ? oh(id1_q) : oh(id0_q);

  always_comb begin
    if (cur_wr || dirty_q)              need = others;
    else if (!hit && (vld_q == 2'b11))  need = evict;
    else                                need = '0;
  end

  assign pend_left = pend_q & ~ack_mask;
  assign go_done   = (accept && (need == '0)) ||
                     ((st == S_WAIT) && (pend_left == '0));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      op_wr_q <= 1'b0;
      op_id_q <= '0;
      pend_q  <= '0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          op_wr_q <= req_write;
          op_id_q <= req_id;
          pend_q  <= need;
          st      <= (need == '0) ? S_DONE : S_INV;
        end
        S_INV: begin
          pend_q <= pend_left;
          st     <= S_WAIT;
        end
        S_WAIT: begin
          pend_q <= pend_left;
          if (pend_left == '0) st <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dirty_q <= 1'b0;
      vld_q   <= 2'b00;
      id0_q   <= '0;
      id1_q   <= '0;
      repl_q  <= 1'b0;
    end else if (go_done) begin
      if (cur_wr) begin
        dirty_q <= 1'b1;
        vld_q   <= 2'b01;
        id0_q   <= cur_id;
      end else if (hit) begin
        dirty_q <= dirty_q;
      end else if (dirty_q) begin
        dirty_q <= 1'b0;
        vld_q   <= 2'b01;
        id0_q   <= cur_id;
      end else if (!vld_q[0]) begin
        vld_q[0] <= 1'b1;
        id0_q    <= cur_id;
      end else if (!vld_q[1]) begin
        vld_q[1] <= 1'b1;
        id1_q    <= cur_id;
      end else begin
        if (repl_q) id1_q <= cur_id;
        else        id0_q <= cur_id;
        repl_q <= ~repl_q;
      end
    end
  end

  assign inv_valid   = (st == S_INV);
  assign inv_mask    = inv_valid ? pend_q : '0;
  assign grant_valid = (st == S_DONE);
  assign grant_write = grant_valid && op_wr_q;
  assign grant_id    = op_id_q;
  assign dir_dirty   = dirty_q;
  assign ptr_vld     = vld_q;
  assign ptr_id      = {id1_q, id0_q};

  AST_DIRTY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    dir_dirty |-> (ptr_vld == 2'b01)); // R8
  AST_NO_DUP_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_vld == 2'b11) |-> (ptr_id[IDW-1:0] != ptr_id[2*IDW-1:IDW])); // R8
  AST_GRANT_AFTER_ACKS: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> (pend_q == '0)); // R7
  AST_INV_THEN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |=> (!grant_valid && !req_ready)); // R7
  AST_WRITER_SPARED: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid && op_wr_q) |-> !inv_mask[op_id_q]); // R5
  AST_ACCEPT_ACTS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (grant_valid || inv_valid)); // R2
  AST_INV_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |-> ($countones(inv_mask) inside {1, 2})); // R4

endmodule

// File: tb/lp_dir_entry_tb.sv
module lp_dir_entry_tb;
  localparam int NC = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_write;
  logic [IW-1:0] req_id;
  logic          req_ready, inv_valid, grant_valid, grant_write, dir_dirty;
  logic [NC-1:0] inv_mask, ack_mask;
  logic [IW-1:0] grant_id;
  logic [1:0]    ptr_vld;
  logic [2*IW-1:0] ptr_id;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  lp_dir_entry #(.NCACHE(NC)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_id(req_id), .req_ready(req_ready), .inv_valid(inv_valid),
    .inv_mask(inv_mask), .ack_mask(ack_mask), .grant_valid(grant_valid),
    .grant_write(grant_write), .grant_id(grant_id), .dir_dirty(dir_dirty),
    .ptr_vld(ptr_vld), .ptr_id(ptr_id)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_entry(input string tag, input bit d, input logic [1:0] v,
                           input int i0, input int i1);
    chk(dir_dirty == d, {tag, " dirty"}, dir_dirty, d);
    chk(ptr_vld == v, {tag, " valid"}, ptr_vld, v);
    if (v[0]) chk(ptr_id[IW-1:0] == i0, {tag, " slot0"}, ptr_id[IW-1:0], i0);
    if (v[1]) chk(ptr_id[2*IW-1:IW] == i1, {tag, " slot1"}, ptr_id[2*IW-1:IW], i1);
  endtask

  // Issues a request; exp_inv = expected invalidation mask (0 = none).
  // split: acknowledge one cache first, with a stray bit, then the rest.
  task automatic do_req(input string tag, input bit wr, input int id,
                        input logic [NC-1:0] exp_inv, input bit split);
    logic [NC-1:0] first;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_id = id[IW-1:0];
    @(negedge clk);
    req_valid = 1'b0;
    if (exp_inv == '0) begin
      chk(inv_valid == 1'b0, {tag, " no inv"}, inv_valid, 0);
    end else begin
      chk(inv_valid && inv_mask == exp_inv, {tag, " inv mask"}, inv_mask, exp_inv);
      chk(grant_valid == 1'b0, {tag, " R7 no grant during inv"}, grant_valid, 0);
      @(negedge clk);
      chk(req_ready == 1'b0, {tag, " R7 busy"}, req_ready, 0);
      if (split) begin
        first = exp_inv & (~exp_inv + 1'b1);
        ack_mask = first | (~exp_inv & ~(exp_inv - 1'b1) & 8'h04) | 8'h04 & ~exp_inv;
        @(negedge clk);
        ack_mask = '0;
        chk(grant_valid == 1'b0, {tag, " R7 R9 partial ack holds grant"}, grant_valid, 0);
        @(negedge clk);
        chk(grant_valid == 1'b0, {tag, " R7 still waiting"}, grant_valid, 0);
        ack_mask = exp_inv & ~first;
      end else begin
        ack_mask = exp_inv;
      end
      @(negedge clk);
      ack_mask = '0;
    end
    chk(grant_valid == 1'b1, {tag, " grant"}, grant_valid, 1);
    chk(grant_id == id[IW-1:0], {tag, " grant id"}, grant_id, id);
    chk(grant_write == wr, {tag, " grant kind"}, grant_write, wr);
  endtask

  initial begin
    int cyc = 0;
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_id = '0; ack_mask = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
    chk(grant_valid == 1'b0 && inv_valid == 1'b0, "R1 quiet", {grant_valid, inv_valid}, 0);
    chk_entry("R1", 0, 2'b00, 0, 0);

    // R2: first reader into slot 0, second into slot 1
    do_req("R2 read c3", 0, 3, '0, 0);
    chk_entry("R2 after c3", 0, 2'b01, 3, 0);
    @(negedge clk);
    chk(req_ready == 1'b1, "R7 ready after grant", req_ready, 1);

    // R3: repeated read
    do_req("R3 reread c3", 0, 3, '0, 0);
    chk_entry("R3 unchanged", 0, 2'b01, 3, 0);

    do_req("R2 read c5", 0, 5, '0, 0);
    chk_entry("R2 after c5", 0, 2'b11, 3, 5);

    // R4: eviction alternates slot 0 then slot 1
    do_req("R4 read c6 evicts slot0", 0, 6, 8'h08, 0);
    chk_entry("R4 after c6", 0, 2'b11, 6, 5);
    do_req("R4 read c1 evicts slot1", 0, 1, 8'h20, 0);
    chk_entry("R4 after c1", 0, 2'b11, 6, 1);
    do_req("R3 reread c1", 0, 1, '0, 0);
    chk_entry("R3 unchanged two", 0, 2'b11, 6, 1);

    // R5 R7 R9: write by unrecorded c7, split acks with a stray bit for c2
    do_req("R5 write c7", 1, 7, 8'h42, 1);
    chk_entry("R5 after c7", 1, 2'b01, 7, 0);

    // R5: owner rewrites, no invalidation
    do_req("R5 owner rewrite c7", 1, 7, '0, 0);
    chk_entry("R5 owner kept", 1, 2'b01, 7, 0);

    // R3: owner reads its dirty block
    do_req("R3 owner read c7", 0, 7, '0, 0);
    chk_entry("R3 dirty kept", 1, 2'b01, 7, 0);

    // R6: other reader on dirty block
    do_req("R6 read c2", 0, 2, 8'h80, 0);
    chk_entry("R6 after c2", 0, 2'b01, 2, 0);

    // R5: write by recorded sharer, other sharer invalidated
    do_req("R2 read c4", 0, 4, '0, 0);
    chk_entry("R2 after c4", 0, 2'b11, 2, 4);
    do_req("R5 write c4", 1, 4, 8'h04, 0);
    chk_entry("R5 after c4", 1, 2'b01, 4, 0);

    @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule